// File: doc/BRIEF.md
# Secure Seconds Counter with Alarm

This block keeps wall-clock time as a single binary count that advances once per cycle of a slow 32768 Hz reference. The upper part of the count is whole seconds. The lower part is a binary fraction of a second. Software reads both parts through a small register window that runs on the fast bus clock. The slow reference arrives as a one-cycle strobe, `slow_tick`, which is synchronous to the bus clock. Each strobe stands for one slow-clock period.

Software sets the time by writing the seconds register. That value reaches the counter only after a fixed number of slow ticks, which models the hop into the slow domain. Until the load happens, reads return the running, older time. An alarm register holds a seconds value. When the seconds count reaches it, a sticky status flag is raised. That flag drives an interrupt line and a wakeup line, each through its own enable bit. The counter also raises a second sticky flag when it wraps past its maximum value. Once a lock bit is set, the time can no longer be written.

Register offsets (byte addresses on `bus_addr`):

| Offset | Contents |
|---|---|
| 0x00 | seconds |
| 0x04 | fraction |
| 0x08 | alarm |
| 0x10 | control |
| 0x14 | status |

Top module: `secure_seconds_counter`

## Requirements
- R1: After reset, all of the following read as zero: seconds, fraction, alarm, control and status. Both `alarm_irq` and `alarm_wake` are low after reset.
- R2: The count advances by one on each `slow_tick` only while control bit 3 (run) is 1. While run is 0, the count holds its value.
- R3: The count is SEC_W+FRAC_W bits wide. Seconds form the upper SEC_W bits and read at 0x00. The FRAC_W-bit fraction reads at 0x04, left-aligned into bits 31:32-FRAC_W, and every lower bit reads 0.
- R4: A write to 0x04 has no effect on the count.
- R5: A write to 0x00 loads the count on the SYNC_TICKS-th `slow_tick` after the write. Until then, reads return the old, still running time. A later write to 0x00 restarts the wait with the new value.
- R6: Loading a new seconds value clears the fraction to zero. On that tick the load takes precedence over counting.
- R7: Status bit 3 (alarm) sets when the seconds count becomes equal to the alarm register at 0x08. It stays set while seconds move on.
- R8: Status bits are write-one-to-clear. Writing 0 to a status bit leaves it unchanged. Writing 0xFFFFFFFF clears every flag.
- R9: `alarm_irq` equals status bit 3 AND control bit 7. `alarm_wake` equals status bit 3 AND control bit 4.
- R10: When the full count wraps from all ones to zero, status bit 5 (rollover) sets.
- R11: Control bit 8 (lock), once written as 1, stays 1 until reset. While lock is 1, writes to 0x00 are ignored. Control reads back bits 3, 4, 7 and 8, and every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| slow_tick | input | 1 | One-cycle strobe per slow reference period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt |
| alarm_wake | output | 1 | Alarm wakeup request |

## Verification
The bench builds the block with FRAC_W = 4 and SYNC_TICKS = 3, keeping SEC_W = 32. With a 4-bit fraction, a second is only sixteen strobes. This makes the carry into seconds, several alarm matches and a full wrap of the count reachable in a few hundred cycles, once the seconds register is preset to all ones. Three-tick synchronization lets the bench read the old value between the write and the load, and see the load land on the third strobe.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_SEC   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_FRAC  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_ALARM = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h14;

  localparam int unsigned CB_RUN   = 3;
  localparam int unsigned CB_WAKE  = 4;
  localparam int unsigned CB_IRQEN = 7;
  localparam int unsigned CB_LOCK  = 8;

  localparam int unsigned SB_ALARM = 3;
  localparam int unsigned SB_ROLL  = 5;

  typedef struct packed {
    logic lock;
    logic irq_en;
    logic wake_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/ssc_wsync.sv
module ssc_wsync #(
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned SYNC_TICKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [SEC_W-1:0] start_val,
  output logic             fire,
  output logic [SEC_W-1:0] load_val,
  output logic             pending
);
  localparam int unsigned CW = $clog2(SYNC_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(SYNC_TICKS - 1);

  logic [CW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      seen_q   <= '0;
      load_val <= '0;
    end else if (start) begin
      pending  <= 1'b1;
      seen_q   <= '0;
      load_val <= start_val;
    end else if (pending && tick) begin
      if (seen_q == LAST) pending <= 1'b0;
      else                seen_q  <= seen_q + 1'b1;
    end
  end

  assign fire = pending && tick && !start && (seen_q == LAST);
endmodule

// File: rtl/ssc_timebase.sv
module ssc_timebase #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              load,
  input  logic [SEC_W-1:0]  load_val,
  output logic [SEC_W-1:0]  seconds,
  output logic [FRAC_W-1:0] fraction,
  output logic              wrap
);
  localparam int unsigned CNT_W = SEC_W + FRAC_W;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           count_q <= '0;
    else if (load)        count_q <= {load_val, {FRAC_W{1'b0}}};
    else if (run && tick) count_q <= count_q + 1'b1;
  end

  assign seconds  = count_q[CNT_W-1:FRAC_W];
  assign fraction = count_q[FRAC_W-1:0];
  assign wrap     = run && tick && !load && (&count_q);
endmodule

// File: rtl/secure_seconds_counter.sv
module secure_seconds_counter #(
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned FRAC_W     = 15,
  parameter int unsigned SYNC_TICKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        alarm_irq,
  output logic        alarm_wake
);
  import ssc_pkg::*;

  localparam int unsigned CNT_W = SEC_W + FRAC_W;
  localparam int unsigned PAD_W = REG_W - FRAC_W;

  ctrl_t            ctl_q;
  logic [SEC_W-1:0] alarm_q;
  logic             st_alarm_q, st_roll_q;
  logic             match_d_q;

  logic [SEC_W-1:0]  seconds;
  logic [FRAC_W-1:0] fraction;
  logic              wrap, load_fire, sync_pending;
  logic [SEC_W-1:0]  load_val;

  logic wr_sec, wr_alarm, wr_ctrl, wr_stat;
  assign wr_sec   = bus_wr && (bus_addr == OFS_SEC) && !ctl_q.lock;
  assign wr_alarm = bus_wr && (bus_addr == OFS_ALARM);
  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_stat  = bus_wr && (bus_addr == OFS_STAT);

  ssc_wsync #(.SEC_W(SEC_W), .SYNC_TICKS(SYNC_TICKS)) wsync_i (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick),
    .start(wr_sec), .start_val(bus_wdata[SEC_W-1:0]),
    .fire(load_fire), .load_val(load_val), .pending(sync_pending)
  );

  ssc_timebase #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) tb_i (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .run(ctl_q.run),
    .load(load_fire), .load_val(load_val),
    .seconds(seconds), .fraction(fraction), .wrap(wrap)
  );

  logic match, alarm_hit;
  assign match     = (seconds == alarm_q);
  assign alarm_hit = match && !match_d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      alarm_q    <= '0;
      st_alarm_q <= 1'b0;
      st_roll_q  <= 1'b0;
      match_d_q  <= 1'b1;
    end else begin
      match_d_q <= match;
      if (wr_ctrl) begin
        ctl_q.run     <= bus_wdata[CB_RUN];
        ctl_q.wake_en <= bus_wdata[CB_WAKE];
        ctl_q.irq_en  <= bus_wdata[CB_IRQEN];
        ctl_q.lock    <= ctl_q.lock | bus_wdata[CB_LOCK];
      end
      if (wr_alarm) alarm_q <= bus_wdata[SEC_W-1:0];
      st_alarm_q <= (st_alarm_q && !(wr_stat && bus_wdata[SB_ALARM])) || alarm_hit;
      st_roll_q  <= (st_roll_q  && !(wr_stat && bus_wdata[SB_ROLL]))  || wrap;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_SEC:   bus_rdata = REG_W'(seconds);
      OFS_FRAC:  bus_rdata = {fraction, {PAD_W{1'b0}}};
      OFS_ALARM: bus_rdata = REG_W'(alarm_q);
      OFS_CTRL: begin
        bus_rdata[CB_RUN]   = ctl_q.run;
        bus_rdata[CB_WAKE]  = ctl_q.wake_en;
        bus_rdata[CB_IRQEN] = ctl_q.irq_en;
        bus_rdata[CB_LOCK]  = ctl_q.lock;
      end
      OFS_STAT: begin
        bus_rdata[SB_ALARM] = st_alarm_q;
        bus_rdata[SB_ROLL]  = st_roll_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign alarm_irq  = st_alarm_q && ctl_q.irq_en;
  assign alarm_wake = st_alarm_q && ctl_q.wake_en;

  logic [CNT_W-1:0] count_view;
  assign count_view = {seconds, fraction};
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int unsigned CW = 47
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [5:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          irq,
  input logic          run,
  input logic          irq_en,
  input logic          lock,
  input logic          st_alarm,
  input logic          st_roll,
  input logic          load_fire,
  input logic [CW-1:0] count
);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && st_alarm));

  // R7
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_alarm && !(bus_wr && bus_addr == 6'h14 && bus_wdata[3])) |=> st_alarm);

  // R10
  roll_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_roll && !(bus_wr && bus_addr == 6'h14 && bus_wdata[5])) |=> st_roll);

  // R2
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_fire) |=> $stable(count));

  // R11
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
endmodule

bind secure_seconds_counter ssc_checker #(.CW(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(alarm_irq), .run(ctl_q.run),
  .irq_en(ctl_q.irq_en), .lock(ctl_q.lock), .st_alarm(st_alarm_q),
  .st_roll(st_roll_q), .load_fire(load_fire), .count(count_view)
);

// File: tb/secure_seconds_counter_tb.sv
module secure_seconds_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        alarm_irq, alarm_wake;

  always #2 clk = ~clk;

  secure_seconds_counter #(.SEC_W(32), .FRAC_W(4), .SYNC_TICKS(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_irq(alarm_irq), .alarm_wake(alarm_wake)
  );

  typedef struct {
    logic [31:0] d;
    logic        irq;
    logic        wake;
    string       tag;
  } item_t;

  item_t q[$];
  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      vectors++;
      if (bus_rdata !== it.d || alarm_irq !== it.irq || alarm_wake !== it.wake) begin
        misses++;
        $display("FAIL %s: rdata=%h irq=%b wake=%b expected rdata=%h irq=%b wake=%b",
                 it.tag, bus_rdata, alarm_irq, alarm_wake, it.d, it.irq, it.wake);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic probe(input logic [5:0] a, input logic [31:0] d,
                       input logic irq, input logic wake, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.d = d; it.irq = irq; it.wake = wake; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; slow_tick = 1'b1;
      @(posedge clk); #1; slow_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    probe(6'h00, 32'h0, 0, 0, "R1 seconds");
    probe(6'h04, 32'h0, 0, 0, "R1 fraction");
    probe(6'h08, 32'h0, 0, 0, "R1 alarm");
    probe(6'h10, 32'h0, 0, 0, "R1 control");
    probe(6'h14, 32'h0, 0, 0, "R1 status");
    // R2 stopped while run is 0
    tk(5);
    probe(6'h04, 32'h0, 0, 0, "R2 halted fraction");
    wr(6'h10, 32'h008);
    tk(3);
    probe(6'h04, 32'h3000_0000, 0, 0, "R3 fraction left aligned");
    tk(13);
    probe(6'h00, 32'h1, 0, 0, "R3 carry into seconds");
    probe(6'h04, 32'h0, 0, 0, "R3 fraction after carry");
    // R4 fraction write ignored
    wr(6'h04, 32'hFFFF_FFFF);
    probe(6'h04, 32'h0, 0, 0, "R4 fraction unchanged");
    probe(6'h00, 32'h1, 0, 0, "R4 seconds unchanged");
    // R5 / R6 delayed load
    wr(6'h00, 32'h100);
    probe(6'h00, 32'h1, 0, 0, "R5 old value before ticks");
    tk(2);
    probe(6'h00, 32'h1, 0, 0, "R5 old value after two ticks");
    probe(6'h04, 32'h2000_0000, 0, 0, "R5 still counting");
    tk(1);
    probe(6'h00, 32'h100, 0, 0, "R5 loaded on third tick");
    probe(6'h04, 32'h0, 0, 0, "R6 fraction cleared");
    // R7 / R9 alarm
    wr(6'h08, 32'h102);
    wr(6'h10, 32'h098);
    tk(32);
    probe(6'h14, 32'h08, 1, 1, "R7 alarm flag set");
    probe(6'h00, 32'h102, 1, 1, "R7 seconds at alarm");
    tk(16);
    probe(6'h14, 32'h08, 1, 1, "R7 flag sticky");
    // R8 write-one-to-clear
    wr(6'h14, 32'h20);
    probe(6'h14, 32'h08, 1, 1, "R8 zero bit leaves flag");
    wr(6'h14, 32'h08);
    probe(6'h14, 32'h00, 0, 0, "R8 one clears flag");
    // R9 enable gating
    wr(6'h10, 32'h008);
    wr(6'h08, 32'h104);
    tk(16);
    probe(6'h14, 32'h08, 0, 0, "R9 flag without enables");
    wr(6'h10, 32'h088);
    probe(6'h14, 32'h08, 1, 0, "R9 irq only");
    wr(6'h14, 32'hFFFF_FFFF);
    probe(6'h14, 32'h00, 0, 0, "R8 clear all");
    // R10 rollover
    wr(6'h10, 32'h008);
    wr(6'h00, 32'hFFFF_FFFF);
    tk(3);
    probe(6'h00, 32'hFFFF_FFFF, 0, 0, "R10 preset top");
    tk(15);
    probe(6'h04, 32'hF000_0000, 0, 0, "R10 fraction full");
    tk(1);
    probe(6'h00, 32'h0, 0, 0, "R10 wrapped seconds");
    probe(6'h14, 32'h20, 0, 0, "R10 rollover flag");
    // R11 lock
    wr(6'h10, 32'h108);
    wr(6'h00, 32'h500);
    tk(3);
    probe(6'h00, 32'h0, 0, 0, "R11 locked write ignored");
    probe(6'h04, 32'h3000_0000, 0, 0, "R11 counter kept running");
    wr(6'h10, 32'h008);
    probe(6'h10, 32'h108, 0, 0, "R11 lock sticky");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule